// File: doc/BRIEF.md
# MDIO Management Master

This block is the bus-side master for clause-22 station management toward an Ethernet PHY. It generates the management clock (MDC) and drives or releases the bidirectional data line (MDIO). A host issues a single transaction by pulsing `start` with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block holds `busy` for the whole frame, pulses `done` at the end, and for reads returns the 16-bit register value or raises `ta_err` when the PHY does not answer the turnaround.

Each frame bit lasts two MDC half-periods. MDC is low in the first half and high in the second. `HALF_CYC` sets the number of system clock cycles in one half-period. Every frame begins with a full preamble, so no PHY ever misses a resynchronisation. When a read gets no turnaround, the block keeps clocking with the line released so that a confused PHY falls back into sync before the next request.

The pad is presented as three signals: a drive value, a drive enable and the sampled input. Outside the block, an undriven line resolves to 1 through a pull-up.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever `busy` is low, `mdc` is 0 and `mdio_oe` is 0.
- R2: Every frame begins with 32 bits in which the master drives MDIO to 1 (`mdio_oe`=1, `mdio_o`=1).
- R3: The 4 bits after the preamble are the start pattern 0,1, followed by opcode 1,0 for a read (`op_read`=1) or 0,1 for a write (`op_read`=0).
- R4: The next 10 bits carry `phy_addr` and then `reg_addr`, each 5 bits and most significant bit first.
- R5: Each frame bit is `HALF_CYC` clock cycles with `mdc` low followed by `HALF_CYC` cycles with `mdc` high. `mdio_o` and `mdio_oe` change only at the start of the low half.
- R6: A write drives turnaround 1,0 (bits 46 and 47) and then `wr_data` MSB first (bits 48 to 63). It releases MDIO for one final bit, so the frame has 65 MDC rising edges.
- R7: A read releases MDIO from bit 46 onward. It samples the line at the end of the high half of bit 47, expecting 0. It then captures 16 data bits MSB first at the end of the high halves of bits 48 to 63 and ends with one more released bit, for 65 MDC rising edges in total. `rd_data` then holds the captured value and `ta_err` is 0.
- R8: If the turnaround sample of a read is 1, the block captures no data and gives 32 further released MDC cycles, for 80 rising edges in total. It ends with `ta_err`=1 and `rd_data`=0.
- R9: `busy` rises in the cycle after an accepted `start` and falls together with a one-cycle `done` pulse.
- R10: A `start` received while `busy` is high is ignored. The frame in progress keeps its original fields and length.
- R11: `rd_data` and `ta_err` are cleared by an accepted `start` and otherwise hold their values, including while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| op_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Captured read data |
| ta_err | output | 1 | Read turnaround was not driven low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line drive value |
| mdio_oe | output | 1 | Line drive enable |
| mdio_i | input | 1 | Resolved line value |

## Verification
The assertions check the following on every cycle:
- the idle line state;
- that the drive value and enable stay still while MDC is high;
- the single-cycle `done` pulse;
- that request fields are frozen under a second `start`;
- that results stay stable while idle;
- that the line is released through the read turnaround and data phases.

Other properties need the bench's scenarios because they depend on the whole frame:
- the exact bit content of the header;
- the turnaround and data order;
- the frame lengths of 65 or 80 edges;
- the captured value;
- the MDC period.

The bench checks these with a model PHY over a sweep of all 32 PHY addresses for both reads and writes, plus non-responding reads.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        ta_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int CW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int IW      = 7;
  localparam int PRE_N   = 32;
  localparam int DATA_N  = 16;
  localparam int RECOV_N = 32;
  localparam int ST0     = PRE_N;
  localparam int OP0     = ST0 + 2;
  localparam int PA0     = OP0 + 2;
  localparam int RA0     = PA0 + 5;
  localparam int TA0     = RA0 + 5;
  localparam int DT0     = TA0 + 2;
  localparam int TAIL    = DT0 + DATA_N;
  localparam int RLAST   = DT0 + RECOV_N - 1;

  localparam logic [IW-1:0] TA_IDX    = IW'(TA0);
  localparam logic [IW-1:0] TA2_IDX   = IW'(TA0 + 1);
  localparam logic [IW-1:0] DT_IDX    = IW'(DT0);
  localparam logic [IW-1:0] TAIL_IDX  = IW'(TAIL);
  localparam logic [IW-1:0] RLAST_IDX = IW'(RLAST);
  localparam logic [CW-1:0] HC_LAST   = CW'(HALF_CYC - 1);

  logic          busy_q, done_q, rd_q, mdc_q, oe_q, o_q, err_q;
  logic [4:0]    pa_q, ra_q;
  logic [15:0]   wd_q, rdata_q;
  logic [IW-1:0] idx_q, last_idx;
  logic [CW-1:0] hcnt_q;
  logic          half_end;

  // {drive enable, drive value} for frame bit i
  function automatic logic [1:0] drive(input logic [IW-1:0] i, input logic rd,
                                       input logic [4:0] pa, input logic [4:0] ra,
                                       input logic [15:0] wd);
    int ii;
    logic [4:0]  s5;
    logic [15:0] s16;
    ii = int'(i);
    if (ii < ST0)             drive = 2'b11;
    else if (ii == ST0)       drive = 2'b10;
    else if (ii == ST0 + 1)   drive = 2'b11;
    else if (ii == OP0)       drive = {1'b1, rd};
    else if (ii == OP0 + 1)   drive = {1'b1, !rd};
    else if (ii < RA0) begin
      s5 = pa << (ii - PA0);
      drive = {1'b1, s5[4]};
    end else if (ii < TA0) begin
      s5 = ra << (ii - RA0);
      drive = {1'b1, s5[4]};
    end else if (ii < DT0)    drive = rd ? 2'b00 : ((ii == TA0) ? 2'b11 : 2'b10);
    else if (ii < TAIL) begin
      s16 = wd << (ii - DT0);
      drive = rd ? 2'b00 : {1'b1, s16[15]};
    end else                  drive = 2'b00;
  endfunction

  assign half_end = (hcnt_q == HC_LAST);
  assign last_idx = (rd_q && err_q) ? RLAST_IDX : TAIL_IDX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      pa_q    <= '0;
      ra_q    <= '0;
      wd_q    <= '0;
      idx_q   <= '0;
      hcnt_q  <= '0;
      mdc_q   <= 1'b0;
      oe_q    <= 1'b0;
      o_q     <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          rd_q    <= op_read;
          pa_q    <= phy_addr;
          ra_q    <= reg_addr;
          wd_q    <= wr_data;
          idx_q   <= '0;
          hcnt_q  <= '0;
          mdc_q   <= 1'b0;
          oe_q    <= 1'b1;
          o_q     <= 1'b1;
          rdata_q <= '0;
          err_q   <= 1'b0;
        end
      end else if (!half_end) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        hcnt_q <= '0;
        if (!mdc_q) begin
          mdc_q <= 1'b1;
        end else begin
          mdc_q <= 1'b0;
          if (rd_q && idx_q == TA2_IDX && mdio_i)
            err_q <= 1'b1;
          if (rd_q && !err_q && idx_q >= DT_IDX && idx_q < TAIL_IDX)
            rdata_q <= {rdata_q[14:0], mdio_i};
          if (idx_q == last_idx) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            oe_q   <= 1'b0;
            o_q    <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
            {oe_q, o_q} <= drive(idx_q + 1'b1, rd_q, pa_q, ra_q, wd_q);
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rdata_q;
  assign ta_err  = err_q;
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_q && !oe_q));

  // R5
  line_still_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_q |-> $stable({oe_q, o_q}));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && idx_q >= TA_IDX) |-> !oe_q);

  // R8
  err_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> rd_q);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // R10
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable({rd_q, pa_q, ra_q, wd_q, idx_q}) || $past(half_end));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable({rdata_q, err_q}));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 2;
  localparam int TCLK = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, done, ta_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        phy_oe = 1'b0, phy_o = 1'b0, phy_en = 1'b0;
  logic [15:0] phy_data = '0;
  logic        line;

  int checks = 0, errors = 0, rcnt = 0, fcnt = 0, clash = 0;
  logic [79:0] val_log, oe_log;
  time t1, t2;

  always #(TCLK/2) clk = ~clk;

  assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .ta_err(ta_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line));

  always @(posedge mdc) begin
    if (rcnt < 80) begin
      val_log[rcnt[6:0]] = line;
      oe_log[rcnt[6:0]]  = mdio_oe;
    end
    if (rcnt == 1) t1 = $time;
    if (rcnt == 2) t2 = $time;
    if (mdio_oe && phy_oe) clash++;
    rcnt++;
  end

  always @(negedge mdc) begin
    logic [15:0] sh;
    fcnt++;
    if (phy_en && val_log[34] && !val_log[35]) begin
      if (fcnt == 47) begin
        phy_oe = 1'b1;
        phy_o  = 1'b0;
      end else if (fcnt >= 48 && fcnt <= 63) begin
        sh = phy_data << (fcnt - 48);
        phy_o = sh[15];
      end else if (fcnt == 64) begin
        phy_oe = 1'b0;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input logic phy_on, input logic [15:0] pd,
                     input logic poke);
    int guard;
    logic [45:0] hdr, ehdr;
    logic [17:0] tl;
    phy_en = phy_on; phy_data = pd; phy_oe = 1'b0;
    rcnt = 0; fcnt = 0; val_log = '0; oe_log = '0;
    @(negedge clk);
    op_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (100) @(negedge clk);
      op_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R9 watchdog done", 64'(done), 64'd1);
    chk(busy == 1'b0, "R9 busy with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", 64'(done), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frame", 64'({mdc, mdio_oe}), 64'd0);
    hdr = '0;
    for (int k = 0; k < 46; k++) hdr = {hdr[44:0], val_log[k[6:0]]};
    ehdr = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    chk(hdr[45:14] == 32'hFFFF_FFFF && &oe_log[31:0], "R2 preamble", 64'(hdr[45:14]), 64'hFFFF_FFFF);
    chk(hdr[13:10] == ehdr[13:10] && &oe_log[35:32], "R3 start/opcode", 64'(hdr[13:10]), 64'(ehdr[13:10]));
    chk(hdr[9:0] == ehdr[9:0] && &oe_log[45:36], "R4 addresses", 64'(hdr[9:0]), 64'(ehdr[9:0]));
    chk((t2 - t1) == 64'(2 * HALF * TCLK), "R5 bit period", 64'(t2 - t1), 64'(2 * HALF * TCLK));
    if (!rd) begin
      tl = '0;
      for (int k = 46; k < 64; k++) tl = {tl[16:0], val_log[k[6:0]]};
      chk(tl == {2'b10, wd}, "R6 turnaround+data", 64'(tl), 64'({2'b10, wd}));
      chk(&oe_log[63:46] && !oe_log[64], "R6 drive then release", 64'(oe_log[64:46]), 64'h3FFFF);
      chk(rcnt == 65, "R6 write length", 64'(rcnt), 64'd65);
    end else if (phy_on) begin
      chk(rd_data == pd, "R7 read data", 64'(rd_data), 64'(pd));
      chk(ta_err == 1'b0, "R7 no error", 64'(ta_err), 64'd0);
      chk(oe_log[64:46] == '0, "R7 released", 64'(oe_log[64:46]), 64'd0);
      chk(rcnt == 65, "R7 read length", 64'(rcnt), 64'd65);
    end else begin
      chk(ta_err == 1'b1, "R8 error flag", 64'(ta_err), 64'd1);
      chk(rd_data == 16'h0, "R8 no capture", 64'(rd_data), 64'd0);
      chk(oe_log[79:46] == '0, "R8 released recovery", 64'(oe_log[79:46]), 64'd0);
      chk(rcnt == 80, "R8 recovery length", 64'(rcnt), 64'd80);
    end
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && busy == 1'b0 && done == 1'b0,
        "R1 reset state", 64'({mdc, mdio_oe, busy, done}), 64'd0);

    for (int p = 0; p < 32; p++)
      txn(1'b0, 5'(p), 5'(31 - p), 16'(p * 16'h0811) ^ 16'hA5C3, 1'b0, 16'h0, 1'b0);
    for (int p = 0; p < 32; p++)
      txn(1'b1, 5'(p), 5'(p ^ 21), 16'h0, 1'b1, ~16'(p * 16'h1357), 1'b0);

    txn(1'b1, 5'd3, 5'd1, 16'h0, 1'b0, 16'h0, 1'b0);
    txn(1'b1, 5'd31, 5'd0, 16'h0, 1'b0, 16'h0, 1'b0);
    txn(1'b1, 5'd7, 5'd2, 16'h0, 1'b1, 16'h8001, 1'b0);
    chk(ta_err == 1'b0, "R11 error cleared by new start", 64'(ta_err), 64'd0);

    // R10: second start during a write is ignored
    txn(1'b0, 5'd10, 5'd20, 16'h1234, 1'b0, 16'h0, 1'b1);
    // R10: second start during a read is ignored
    txn(1'b1, 5'd17, 5'd9, 16'h0, 1'b1, 16'hBEEF, 1'b1);

    held = rd_data;
    op_read = 1'b0; phy_addr = 5'd1; reg_addr = 5'd2; wr_data = 16'hFFFF;
    repeat (50) @(negedge clk);
    chk(rd_data == held && ta_err == 1'b0, "R11 result held while idle", 64'(rd_data), 64'(held));
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && busy == 1'b0, "R1 idle quiet", 64'({mdc, mdio_oe, busy}), 64'd0);
    chk(clash == 0, "R7 no line contention", 64'(clash), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule